// File: doc/BRIEF.md
# Vertical Sync Pulse Detector

The block takes a composite sync stream that has already been sliced to one bit (low while a sync pulse is present) and resampled on the system clock. It watches each pulse and measures two things: the spacing of its falling edge from the previous one, and the time the pulse stays low. From these it can tell narrow equalizing pulses, which come every half line, from wide serration pulses and from ordinary line-rate horizontal pulses.

Once a run of equalizing pulses has been seen, the block drives an active-low vertical sync pulse. The pulse starts on the rising edge that ends the first serration pulse. If no serration pulse arrives, a timer started at the last equalizing falling edge starts it instead. The vertical pulse lasts a fixed number of clocks. It is not started again until the field has gone back to line-rate pulses. If falling edges stop for too long, the block drops to idle, drives its output high and clears its sync-present flag. All timing constants are parameters counted in system clocks. The defaults suit a 27 MHz clock with a 1716-clock line.

Top module: `vsync_detect`

## Requirements
- R1: After reset, vsync_n_o is high and sync_ok_o is low.
- R2: A pulse with fall-to-fall period P and low time L is classed as follows. If 4·P ≥ 3·LINE_CYC it is a line pulse. Otherwise it is equalizing when 5·L < P, serration when 2·L > P, and "other" in all remaining cases. A line pulse never counts as equalizing, whatever its low time.
- R3: The equalizing phase is confirmed only after EQ_NEED (default 3) equalizing pulses in a row. Any other class of pulse seen before that resets the run, and a serration pulse before confirmation launches nothing.
- R4: In the confirmed equalizing phase, the rising edge that ends the first serration pulse drives vsync_n_o low. The output changes three clocks after the rise on csync_n_i: two synchronizer stages plus the state register.
- R5: In the confirmed equalizing phase, if FALLBACK_CYC clocks pass after the last falling edge with no serration, vsync_n_o goes low anyway. This happens FALLBACK_CYC+3 clocks after that falling edge on csync_n_i.
- R6: vsync_n_o stays low for exactly VS_WIDTH clocks, unless sync is lost first.
- R7: After a vertical pulse ends, no new pulse starts until a line pulse has been seen. Serration or equalizing pulses in the same field have no effect.
- R8: Inside the confirmed equalizing phase, a line pulse or an "other" pulse cancels the phase. A serration pulse that follows it does not launch vertical sync.
- R9: If no falling edge is seen for LOSS_CYC clocks, sync_ok_o goes low, vsync_n_o is forced high (ending a pulse early) and the block returns to idle. The next falling edge sets sync_ok_o again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_n_i | input | 1 | Sliced composite sync, low during a sync pulse |
| vsync_n_o | output | 1 | Vertical sync, active low |
| sync_ok_o | output | 1 | High while falling edges arrive within LOSS_CYC |

## Verification
Every result comes from a register fed by a two-stage input synchronizer. The serration launch is therefore due three clocks after the rise on the input, and the fallback launch FALLBACK_CYC+3 clocks after the last equalizing fall. The pulse ends VS_WIDTH clocks after it starts. Loss of sync shows about LOSS_CYC+2 clocks after the last fall. Inputs change on the falling clock edge and outputs are sampled on falling edges. The directed tests sample exactly at the clock before and the clock of each exact transition. The table rows sample at the end of each pulse period, at least 14 clocks after the rise that could have changed the output, and at least 12 clocks away from the end of a vertical pulse.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_EQ,
    ST_VS,
    ST_DONE
  } vsd_state_e;

  typedef enum logic [1:0] {
    PC_OTHER,
    PC_EQ,
    PC_SERR,
    PC_LINE
  } pulse_class_e;
endpackage

// File: rtl/vsd_sync_edge.sv
module vsd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/vsd_pulse_meter.sv
module vsd_pulse_meter
  import vsd_pkg::*;
#(
  parameter int LINE_CYC = 1716,
  parameter int LOSS_CYC = 3432,
  parameter int CW       = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output pulse_class_e  pclass_o,
  output logic [CW-1:0] gap_o,
  output logic          lost_o
);
  localparam int MW = CW + 3;

  logic [CW-1:0] gap_q, per_q, low_q;
  logic [MW-1:0] low_x, per_x;
  logic          is_line, is_eq, is_serr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= CW'(LOSS_CYC);
      per_q <= CW'(LOSS_CYC);
      low_q <= '0;
    end else begin
      if (fall_i) begin
        gap_q <= CW'(1);
        per_q <= gap_q;
      end else if (gap_q < CW'(LOSS_CYC)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (fall_i)
        low_q <= CW'(1);
      else if (!level_i && low_q < CW'(LOSS_CYC))
        low_q <= low_q + 1'b1;
    end
  end

  // ratios against the measured fall-to-fall period
  always_comb begin
    low_x   = MW'(low_q);
    per_x   = MW'(per_q);
    is_line = (per_x * MW'(4)) >= MW'(3 * LINE_CYC);
    is_eq   = !is_line && ((low_x * MW'(5)) < per_x);
    is_serr = !is_line && ((low_x * MW'(2)) > per_x);
    if (is_line)      pclass_o = PC_LINE;
    else if (is_eq)   pclass_o = PC_EQ;
    else if (is_serr) pclass_o = PC_SERR;
    else              pclass_o = PC_OTHER;
  end

  assign gap_o  = gap_q;
  assign lost_o = gap_q >= CW'(LOSS_CYC);

  p_class_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> !(is_eq && is_serr));
  p_fall_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !lost_o);
endmodule

// File: rtl/vsd_seq.sv
module vsd_seq
  import vsd_pkg::*;
#(
  parameter int FALLBACK_CYC = 1620,
  parameter int VS_WIDTH     = 5148,
  parameter int EQ_NEED      = 3,
  parameter int CW           = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  pulse_class_e  pclass_i,
  input  logic [CW-1:0] gap_i,
  input  logic          lost_i,
  output logic          vsync_n_o
);
  localparam int EW = $clog2(EQ_NEED + 1);
  localparam int VW = $clog2(VS_WIDTH + 1);

  vsd_state_e    state_q, state_d;
  logic [EW-1:0] eq_cnt_q, eq_cnt_d;
  logic [VW-1:0] vs_cnt_q, vs_cnt_d;

  always_comb begin
    state_d  = state_q;
    eq_cnt_d = eq_cnt_q;
    vs_cnt_d = vs_cnt_q;
    if (lost_i) begin
      state_d  = ST_IDLE;
      eq_cnt_d = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d  = ST_HUNT;
          eq_cnt_d = '0;
        end
        ST_HUNT: if (rise_i) begin
          if (pclass_i == PC_EQ) begin
            eq_cnt_d = eq_cnt_q + 1'b1;
            if (eq_cnt_q == EW'(EQ_NEED - 1)) state_d = ST_EQ;
          end else begin
            eq_cnt_d = '0;
          end
        end
        ST_EQ: begin
          if (rise_i && pclass_i == PC_SERR) begin
            state_d  = ST_VS;
            vs_cnt_d = '0;
          end else if (rise_i && pclass_i != PC_EQ) begin
            state_d  = ST_HUNT;
            eq_cnt_d = '0;
          end else if (gap_i == CW'(FALLBACK_CYC)) begin
            state_d  = ST_VS;
            vs_cnt_d = '0;
          end
        end
        ST_VS: begin
          if (vs_cnt_q == VW'(VS_WIDTH - 1)) state_d = ST_DONE;
          else                               vs_cnt_d = vs_cnt_q + 1'b1;
        end
        ST_DONE: if (rise_i && pclass_i == PC_LINE) begin
          state_d  = ST_HUNT;
          eq_cnt_d = '0;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      eq_cnt_q <= '0;
      vs_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      eq_cnt_q <= eq_cnt_d;
      vs_cnt_q <= vs_cnt_d;
    end
  end

  assign vsync_n_o = (state_q != ST_VS);

  p_eq_confirm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_EQ) |-> $past(eq_cnt_q) == EW'(EQ_NEED - 1));
  p_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EQ && rise_i && pclass_i == PC_SERR && !lost_i) |=> !vsync_n_o);
  p_vs_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vsync_n_o) && !$past(lost_i)) |-> $past(vs_cnt_q) == VW'(VS_WIDTH - 1));
  p_no_retrig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> vsync_n_o);
  p_lost_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |=> (state_q == ST_IDLE && vsync_n_o));
endmodule

// File: rtl/vsync_detect.sv
module vsync_detect
  import vsd_pkg::*;
#(
  parameter int LINE_CYC     = 1716,
  parameter int FALLBACK_CYC = 1620,
  parameter int LOSS_CYC     = 2 * LINE_CYC,
  parameter int VS_WIDTH     = 3 * LINE_CYC,
  parameter int EQ_NEED      = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_n_i,
  output logic vsync_n_o,
  output logic sync_ok_o
);
  localparam int CW = $clog2(LOSS_CYC + 1);

  logic          level, rise, fall, lost;
  pulse_class_e  pclass;
  logic [CW-1:0] gap;

  vsd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (csync_n_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  vsd_pulse_meter #(
    .LINE_CYC (LINE_CYC),
    .LOSS_CYC (LOSS_CYC),
    .CW       (CW)
  ) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .rise_i   (rise),
    .fall_i   (fall),
    .pclass_o (pclass),
    .gap_o    (gap),
    .lost_o   (lost)
  );

  vsd_seq #(
    .FALLBACK_CYC (FALLBACK_CYC),
    .VS_WIDTH     (VS_WIDTH),
    .EQ_NEED      (EQ_NEED),
    .CW           (CW)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .pclass_i  (pclass),
    .gap_i     (gap),
    .lost_i    (lost),
    .vsync_n_o (vsync_n_o)
  );

  assign sync_ok_o = ~lost;
endmodule

// File: tb/vsync_detect_bench.sv
module vsync_detect_bench;
  localparam int LINE = 200;
  localparam int FB   = 190;
  localparam int LOSS = 400;
  localparam int VW   = 300;

  // row = {low[9:0], period[9:0], expected vsync_n}
  localparam logic [20:0] H1 = {10'd15, 10'd200, 1'b1};
  localparam logic [20:0] E1 = {10'd7,  10'd100, 1'b1};
  localparam logic [20:0] E0 = {10'd7,  10'd100, 1'b0};
  localparam logic [20:0] S1 = {10'd85, 10'd100, 1'b1};
  localparam logic [20:0] S0 = {10'd85, 10'd100, 1'b0};
  localparam logic [20:0] M1 = {10'd40, 10'd100, 1'b1};
  localparam int NV = 35;
  localparam logic [20:0] VEC [NV] = '{
    H1, H1, E1, E1, E1, E1, S0, S0, S0, E1,
    E1, S1, E1, H1, H1, E1, E1, E1, E1, M1,
    S1, H1, E1, E1, E1, S1, H1, E1, E1, E1,
    E1, S0, S0, H1, H1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n, sync_ok;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vsync_detect #(
    .LINE_CYC (LINE),
    .FALLBACK_CYC (FB),
    .LOSS_CYC (LOSS),
    .VS_WIDTH (VW)
  ) u_vsync_detect (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .csync_n_i (csync_n),
    .vsync_n_o (vsync_n),
    .sync_ok_o (sync_ok)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int lo, input int per);
    @(negedge clk) csync_n = 1'b0;
    repeat (lo) @(negedge clk);
    csync_n = 1'b1;
    repeat (per - lo - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 vsync_n in reset", vsync_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 vsync_n after reset", vsync_n, 1'b1);
    chk("R1 sync_ok after reset", sync_ok, 1'b0);

    // table: classification, confirmation, launch, no retrigger, cancel
    for (int i = 0; i < NV; i++) begin
      pulse(int'(VEC[i][20:11]), int'(VEC[i][10:1]));
      chk($sformatf("R2 R3 R4 R7 R8 row %0d vsync_n", i), vsync_n, VEC[i][0]);
      chk($sformatf("R9 row %0d sync_ok", i), sync_ok, 1'b1);
    end

    // fallback launch with no serration (R5), then loss aborts it (R9)
    for (int i = 0; i < 3; i++) pulse(7, 100);
    @(negedge clk) csync_n = 1'b0;
    repeat (7) @(negedge clk);
    csync_n = 1'b1;
    repeat (FB + 2 - 7) @(negedge clk);
    chk("R5 fallback not before due", vsync_n, 1'b1);
    @(negedge clk);
    chk("R5 fallback launched", vsync_n, 1'b0);
    repeat (395 - (FB + 3)) @(negedge clk);
    chk("R5 fallback pulse held", vsync_n, 1'b0);
    chk("R9 sync_ok before loss", sync_ok, 1'b1);
    repeat (15) @(negedge clk);
    chk("R9 vsync_n forced high on loss", vsync_n, 1'b1);
    chk("R9 sync_ok low on loss", sync_ok, 1'b0);

    // recovery, exact launch latency (R4) and width (R6)
    pulse(15, 200);
    chk("R9 sync_ok back after fall", sync_ok, 1'b1);
    pulse(15, 200);
    for (int i = 0; i < 4; i++) pulse(7, 100);
    @(negedge clk) csync_n = 1'b0;
    repeat (85) @(negedge clk);
    csync_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 not before third clock", vsync_n, 1'b1);
    @(negedge clk);
    chk("R4 launch on serration rise", vsync_n, 1'b0);
    repeat (VW - 1) @(negedge clk);
    chk("R6 low for last width clock", vsync_n, 1'b0);
    @(negedge clk);
    chk("R6 released after width", vsync_n, 1'b1);
    chk("R6 sync_ok still high", sync_ok, 1'b1);

    // reset mid-stream
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 vsync_n in late reset", vsync_n, 1'b1);
    chk("R1 sync_ok in late reset", sync_ok, 1'b0);
    finish_run();
  end
endmodule